// File: doc/BRIEF.md
# Asynchronous Event Notification Dispatcher

This block matches events raised inside a storage controller with notification requests that the host has posted ahead of time and left outstanding. Each event carries a type, an info byte and a log page identifier. Events accepted while the controller is ready go into a small queue. A scan engine then walks that queue and pairs deliverable events with outstanding requests. Each pairing produces one completion record for the admin completion queue. That record carries the request's command identifier, the event fields and a success status.

Every event type has a mask bit. Delivering an event sets the bit for its type. Until the host clears that bit (normally after it reads the related log page), later events of the same type stay in the queue and are skipped. Skipping them does not hold back unmasked events queued behind them. Outstanding requests are kept in a stack, so the most recently posted request is answered first. A post beyond the request limit is refused.

The scan engine has three states. IDLE waits for a rescan to be pending. An accepted raise, a request post or a mask clear makes a rescan pending. IDLE goes to HOLD when a rescan is pending. HOLD waits a fixed number of cycles and then goes to SCAN with the scan index at the oldest entry. SCAN looks at one queue entry per cycle. A masked entry advances the index. An unmasked entry is delivered, is taken out of the queue, and the index stays put. SCAN goes back to IDLE when the index passes the last entry or when no request is outstanding.

Top module: `evn_dispatch`

## Requirements
- R1: A raise presented while `ctrl_ready` is low is discarded and never produces a completion.
- R2: A completion is produced only while at least one request is outstanding. Queued events wait while the count is zero and are delivered after a later post.
- R3: Outstanding requests are answered last-posted first: each delivery takes the command identifier of the newest request still outstanding.
- R4: A completion presents the request's `cpl_cid`, the event's type, info and log page id unchanged, and `cpl_status` equal to 0 (success), for one cycle on `cpl_valid`.
- R5: A queued event whose type is masked stays queued and is passed over. A later unmasked event in the queue is still delivered.
- R6: A delivery sets the mask bit of its type. A pulse on `mask_clr_valid` clears the bit of `mask_clr_type` and starts a rescan, so a waiting event of that type is then delivered.
- R7: A post while LIMIT requests are outstanding is refused: one cycle later `rej_valid` is 1 for one cycle, `rej_cid` equals the refused identifier, and that identifier is never used for a completion.
- R8: A raise that finds DEPTH events queued is discarded and sets `ev_overflow`, which stays 1 until reset. After reset it is 0.
- R9: Among deliverable events, the oldest in the queue is delivered first.
- R10: No delivery occurs earlier than DELAY cycles after the stimulus that started the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_ready | input | 1 | Controller ready; raises are discarded while low |
| ev_valid | input | 1 | Raise an event this cycle |
| ev_type | input | TYPE_W | Event type, selects the mask bit |
| ev_info | input | INFO_W | Event information |
| ev_log | input | LOG_W | Associated log page identifier |
| req_valid | input | 1 | Post a notification request this cycle |
| req_cid | input | CID_W | Command identifier of the posted request |
| mask_clr_valid | input | 1 | Clear one type's mask bit and rescan |
| mask_clr_type | input | TYPE_W | Type whose mask bit is cleared |
| cpl_valid | output | 1 | Completion record valid, one cycle per delivery |
| cpl_cid | output | CID_W | Identifier of the answered request |
| cpl_type | output | TYPE_W | Delivered event type |
| cpl_info | output | INFO_W | Delivered event information |
| cpl_log | output | LOG_W | Delivered log page identifier |
| cpl_status | output | STAT_W | Completion status, 0 = success |
| rej_valid | output | 1 | Previous cycle's post was refused |
| rej_cid | output | CID_W | Identifier of the refused post |
| ev_overflow | output | 1 | Sticky: a raise was lost to a full queue |

## Verification
The bench drives ordered runs of raises, posts and mask clears. Each run separates one pairing rule from the others. Three posts followed by three raises of distinct types show last-posted-first pairing against oldest-event-first ordering. A masked event queued in front of an unmasked one shows that a skip does not block what follows, and a later mask clear shows the rescan. Raises with no request outstanding, answered by later posts, show that the engine stops at a zero count and resumes. A raise while not ready, a fifth raise into a full queue, and a post above the limit check the three ways an input is lost.

// File: rtl/evn_pkg.sv
package evn_pkg;
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_HOLD = 2'd1,
        SC_SCAN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/evn_event_queue.sv
module evn_event_queue #(
    parameter int DEPTH = 4,
    parameter int EW    = 19,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [EW-1:0]    push_data,
    input  logic             rm,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [EW-1:0]    rd_data,
    output logic [CNT_W-1:0] cnt,
    output logic             overflow
);
    logic [EW-1:0]    q     [DEPTH];
    logic [EW-1:0]    q_n   [DEPTH];
    logic [CNT_W-1:0] cnt_n;
    logic             accept;

    assign accept  = push && (cnt != CNT_W'(DEPTH));
    assign rd_data = q[rd_idx];

    // removal at rd_idx compacts later entries downwards, then the push lands at the tail
    always_comb begin
        for (int i = 0; i < DEPTH; i++) q_n[i] = q[i];
        cnt_n = cnt;
        if (rm) begin
            for (int i = 0; i < DEPTH - 1; i++)
                if (i >= int'(rd_idx)) q_n[i] = q[i + 1];
            cnt_n = cnt_n - CNT_W'(1);
        end
        if (accept) begin
            q_n[IDX_W'(cnt_n)] = push_data;
            cnt_n = cnt_n + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            cnt <= cnt_n;
            if (push && !accept) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end

    a_r8_full_raise_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt == CNT_W'(DEPTH)) |=> overflow);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r8_full_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(DEPTH) && !rm) |=> cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/evn_req_stack.sv
module evn_req_stack #(
    parameter int LIMIT = 3,
    parameter int CID_W = 16,
    localparam int SIDX_W = (LIMIT > 1) ? $clog2(LIMIT) : 1,
    localparam int CNT_W  = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CID_W-1:0] push_cid,
    input  logic             pop,
    output logic [CID_W-1:0] top_cid,
    output logic [CNT_W-1:0] cnt,
    output logic             rej_valid,
    output logic [CID_W-1:0] rej_cid
);
    logic [CID_W-1:0] stk [LIMIT];
    logic             accept;
    logic [CNT_W-1:0] wr_pos;

    assign accept  = push && (cnt != CNT_W'(LIMIT));
    assign top_cid = (cnt == '0) ? '0 : stk[SIDX_W'(cnt - CNT_W'(1))];
    // a same-cycle pop frees the top slot before the push reuses it
    assign wr_pos  = pop ? cnt - CNT_W'(1) : cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rej_valid <= 1'b0;
            rej_cid   <= '0;
        end else begin
            cnt       <= cnt + CNT_W'(accept) - CNT_W'(pop);
            rej_valid <= push && !accept;
            rej_cid   <= push_cid;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) stk[SIDX_W'(wr_pos)] <= push_cid;
    end

    a_r2_pop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);
    a_r7_refuse_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> $past(cnt) == CNT_W'(LIMIT));
endmodule

// File: rtl/evn_scan.sv
module evn_scan
    import evn_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int TYPE_W = 3,
    parameter int DELAY  = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int NTYPES = 1 << TYPE_W,
    localparam int DW     = $clog2(DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [CNT_W-1:0]  fcnt,
    input  logic [TYPE_W-1:0] rd_type,
    input  logic              have_req,
    input  logic              clr_valid,
    input  logic [TYPE_W-1:0] clr_type,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              deliver
);
    scan_state_e       state, state_n;
    logic              pend;
    logic [DW-1:0]     dly;
    logic [CNT_W-1:0]  idx;
    logic [NTYPES-1:0] mask;
    logic              in_range, skip;

    assign in_range = (idx < fcnt) && have_req;
    assign rd_idx   = idx[IDX_W-1:0];

    always_comb begin
        state_n = state;
        unique case (state)
            SC_IDLE: if (pend) state_n = SC_HOLD;
            SC_HOLD: if (dly == DW'(DELAY - 1)) state_n = SC_SCAN;
            SC_SCAN: if (!in_range) state_n = SC_IDLE;
            default: state_n = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SC_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        deliver = (state == SC_SCAN) && in_range && !mask[rd_type];
        skip    = (state == SC_SCAN) && in_range &&  mask[rd_type];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            dly  <= '0;
            idx  <= '0;
            mask <= '0;
        end else begin
            pend <= kick || (pend && state != SC_IDLE);
            dly  <= (state == SC_HOLD) ? dly + DW'(1) : '0;
            if (state != SC_SCAN) idx <= '0;
            else if (skip)        idx <= idx + CNT_W'(1);
            for (int t = 0; t < NTYPES; t++) begin
                if (deliver && rd_type == TYPE_W'(t))      mask[t] <= 1'b1;
                else if (clr_valid && clr_type == TYPE_W'(t)) mask[t] <= 1'b0;
            end
        end
    end

    a_r6_mask_set_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> mask[$past(rd_type)]);
    a_r10_hold_before_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_IDLE) |=> state != SC_SCAN);
endmodule

// File: rtl/evn_dispatch.sv
module evn_dispatch #(
    parameter int TYPE_W = 3,
    parameter int INFO_W = 8,
    parameter int LOG_W  = 8,
    parameter int CID_W  = 16,
    parameter int STAT_W = 4,
    parameter int DEPTH  = 4,
    parameter int LIMIT  = 3,
    parameter int DELAY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_ready,
    input  logic              ev_valid,
    input  logic [TYPE_W-1:0] ev_type,
    input  logic [INFO_W-1:0] ev_info,
    input  logic [LOG_W-1:0]  ev_log,
    input  logic              req_valid,
    input  logic [CID_W-1:0]  req_cid,
    input  logic              mask_clr_valid,
    input  logic [TYPE_W-1:0] mask_clr_type,
    output logic              cpl_valid,
    output logic [CID_W-1:0]  cpl_cid,
    output logic [TYPE_W-1:0] cpl_type,
    output logic [INFO_W-1:0] cpl_info,
    output logic [LOG_W-1:0]  cpl_log,
    output logic [STAT_W-1:0] cpl_status,
    output logic              rej_valid,
    output logic [CID_W-1:0]  rej_cid,
    output logic              ev_overflow
);
    localparam int EW     = TYPE_W + INFO_W + LOG_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int FCNT_W = $clog2(DEPTH + 1);
    localparam int RCNT_W = $clog2(LIMIT + 1);
    localparam logic [STAT_W-1:0] ST_OK = '0;

    logic              ev_push, kick, deliver;
    logic [EW-1:0]     rd_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [FCNT_W-1:0] fcnt;
    logic [CID_W-1:0]  top_cid;
    logic [RCNT_W-1:0] rcnt;

    assign ev_push = ev_valid && ctrl_ready;
    assign kick    = ev_push || req_valid || mask_clr_valid;

    evn_event_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(ev_push),
        .push_data({ev_type, ev_info, ev_log}), .rm(deliver),
        .rd_idx(rd_idx), .rd_data(rd_data), .cnt(fcnt), .overflow(ev_overflow));

    evn_req_stack #(.LIMIT(LIMIT), .CID_W(CID_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(req_valid), .push_cid(req_cid),
        .pop(deliver), .top_cid(top_cid), .cnt(rcnt),
        .rej_valid(rej_valid), .rej_cid(rej_cid));

    evn_scan #(.DEPTH(DEPTH), .TYPE_W(TYPE_W), .DELAY(DELAY)) u_scan (
        .clk(clk), .rst_n(rst_n), .kick(kick), .fcnt(fcnt),
        .rd_type(rd_data[EW-1 -: TYPE_W]), .have_req(rcnt != '0),
        .clr_valid(mask_clr_valid), .clr_type(mask_clr_type),
        .rd_idx(rd_idx), .deliver(deliver));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid  <= 1'b0;
            cpl_cid    <= '0;
            cpl_type   <= '0;
            cpl_info   <= '0;
            cpl_log    <= '0;
            cpl_status <= ST_OK;
        end else begin
            cpl_valid <= deliver;
            if (deliver) begin
                cpl_cid    <= top_cid;
                cpl_type   <= rd_data[EW-1 -: TYPE_W];
                cpl_info   <= rd_data[LOG_W +: INFO_W];
                cpl_log    <= rd_data[0 +: LOG_W];
                cpl_status <= ST_OK;
            end
        end
    end

    a_r1_not_ready_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_ready |=> fcnt <= $past(fcnt));
    a_r2_completion_had_request: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(rcnt) != '0);
    a_r4_completion_pulse_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(fcnt) != '0);
endmodule

// File: tb/test_evn_dispatch.sv
module test_evn_dispatch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_ready, ev_valid, req_valid, mask_clr_valid;
    logic [2:0]  ev_type, mask_clr_type;
    logic [7:0]  ev_info, ev_log;
    logic [15:0] req_cid;
    logic        cpl_valid, rej_valid, ev_overflow;
    logic [15:0] cpl_cid, rej_cid;
    logic [2:0]  cpl_type;
    logic [7:0]  cpl_info, cpl_log;
    logic [3:0]  cpl_status;

    typedef struct packed {
        logic [15:0] cid;
        logic [2:0]  t;
        logic [7:0]  info;
        logic [7:0]  lg;
    } exp_t;

    exp_t exp_q[$];
    exp_t got;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    evn_dispatch i_evn_dispatch (
        .clk(clk), .rst_n(rst_n), .ctrl_ready(ctrl_ready),
        .ev_valid(ev_valid), .ev_type(ev_type), .ev_info(ev_info), .ev_log(ev_log),
        .req_valid(req_valid), .req_cid(req_cid),
        .mask_clr_valid(mask_clr_valid), .mask_clr_type(mask_clr_type),
        .cpl_valid(cpl_valid), .cpl_cid(cpl_cid), .cpl_type(cpl_type),
        .cpl_info(cpl_info), .cpl_log(cpl_log), .cpl_status(cpl_status),
        .rej_valid(rej_valid), .rej_cid(rej_cid), .ev_overflow(ev_overflow));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cpl_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected completion cid", 32'(cpl_cid), 32'h0);
            end else begin
                got = exp_q.pop_front();
                check(cpl_cid == got.cid, "R3", "completion cid", 32'(cpl_cid), 32'(got.cid));
                check({cpl_type, cpl_info, cpl_log} == {got.t, got.info, got.lg}, "R4",
                      "event fields", 32'({cpl_type, cpl_info, cpl_log}), 32'({got.t, got.info, got.lg}));
                check(cpl_status == 4'd0, "R4", "status", 32'(cpl_status), 32'h0);
            end
        end
    end

    task automatic expect_cpl(input logic [15:0] cid, input logic [2:0] t,
                              input logic [7:0] inf, input logic [7:0] lg);
        exp_t e;
        e.cid = cid; e.t = t; e.info = inf; e.lg = lg;
        exp_q.push_back(e);
    endtask

    task automatic raise(input logic [2:0] t, input logic [7:0] inf, input logic [7:0] lg);
        @(negedge clk);
        ev_valid = 1'b1; ev_type = t; ev_info = inf; ev_log = lg;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic post(input logic [15:0] cid, input bit exp_rej);
        @(negedge clk);
        req_valid = 1'b1; req_cid = cid;
        @(negedge clk);
        req_valid = 1'b0;
        check(rej_valid == exp_rej, "R7", "refusal flag", 32'(rej_valid), 32'(exp_rej));
        if (exp_rej) check(rej_cid == cid, "R7", "refused cid", 32'(rej_cid), 32'(cid));
    endtask

    task automatic clear_mask(input logic [2:0] t);
        @(negedge clk);
        mask_clr_valid = 1'b1; mask_clr_type = t;
        @(negedge clk);
        mask_clr_valid = 1'b0;
    endtask

    task automatic drained(input string req);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, req, "outstanding expected completions",
              32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion of run");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctrl_ready = 1'b1;
        ev_valid = 1'b0; req_valid = 1'b0; mask_clr_valid = 1'b0;
        ev_type = '0; ev_info = '0; ev_log = '0; req_cid = '0; mask_clr_type = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpl_valid == 1'b0, "R4", "reset cpl_valid", 32'(cpl_valid), 32'h0);
        check(rej_valid == 1'b0, "R7", "reset rej_valid", 32'(rej_valid), 32'h0);
        check(ev_overflow == 1'b0, "R8", "reset overflow", 32'(ev_overflow), 32'h0);

        // R1: raise while not ready is lost
        ctrl_ready = 1'b0;
        raise(3'd0, 8'h11, 8'h10);
        ctrl_ready = 1'b1;
        post(16'h0100, 1'b0);
        drained("R1");
        expect_cpl(16'h0100, 3'd0, 8'h22, 8'h01);
        raise(3'd0, 8'h22, 8'h01);
        drained("R1");

        // R3 / R9: three posts, three raises
        post(16'h0201, 1'b0);
        post(16'h0202, 1'b0);
        post(16'h0203, 1'b0);
        expect_cpl(16'h0203, 3'd1, 8'h31, 8'h02);
        expect_cpl(16'h0202, 3'd2, 8'h32, 8'h03);
        expect_cpl(16'h0201, 3'd3, 8'h33, 8'h04);
        raise(3'd1, 8'h31, 8'h02);
        raise(3'd2, 8'h32, 8'h03);
        raise(3'd3, 8'h33, 8'h04);
        drained("R3");

        // R7: fourth post above the limit
        post(16'h0301, 1'b0);
        post(16'h0302, 1'b0);
        post(16'h0303, 1'b0);
        post(16'h0304, 1'b1);

        // R5: masked type 1 in front, type 4 behind it
        expect_cpl(16'h0303, 3'd4, 8'h42, 8'h06);
        raise(3'd1, 8'h41, 8'h05);
        raise(3'd4, 8'h42, 8'h06);
        drained("R5");

        // R6: clearing type 1 releases the waiting event
        expect_cpl(16'h0302, 3'd1, 8'h41, 8'h05);
        clear_mask(3'd1);
        drained("R6");

        // R2 / R9: engine stops at zero requests, resumes on post
        expect_cpl(16'h0301, 3'd5, 8'h51, 8'h07);
        raise(3'd5, 8'h51, 8'h07);
        drained("R2");
        raise(3'd6, 8'h61, 8'h08);
        raise(3'd7, 8'h71, 8'h09);
        drained("R2");
        expect_cpl(16'h0401, 3'd6, 8'h61, 8'h08);
        post(16'h0401, 1'b0);
        drained("R9");
        expect_cpl(16'h0402, 3'd7, 8'h71, 8'h09);
        post(16'h0402, 1'b0);
        drained("R9");

        // R8: four masked type-0 raises fill the queue, the fifth is lost
        raise(3'd0, 8'h81, 8'h0a);
        raise(3'd0, 8'h82, 8'h0b);
        raise(3'd0, 8'h83, 8'h0c);
        raise(3'd0, 8'h84, 8'h0d);
        check(ev_overflow == 1'b0, "R8", "overflow at exactly full", 32'(ev_overflow), 32'h0);
        raise(3'd0, 8'h85, 8'h0e);
        check(ev_overflow == 1'b1, "R8", "overflow after lost raise", 32'(ev_overflow), 32'h1);
        post(16'h0501, 1'b0);
        drained("R6");
        expect_cpl(16'h0501, 3'd0, 8'h81, 8'h0a);
        clear_mask(3'd0);
        drained("R6");
        post(16'h0502, 1'b0);
        drained("R6");
        expect_cpl(16'h0502, 3'd0, 8'h82, 8'h0b);
        clear_mask(3'd0);
        drained("R9");
        check(ev_overflow == 1'b1, "R8", "overflow stays set", 32'(ev_overflow), 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule